// File: doc/BRIEF.md
# Streaming Co-occurrence Counting Array

This block counts shared neighbours between left-side nodes of a bipartite graph whose adjacency matrix is packed one bit per entry. It holds K counting units. Each unit keeps one adjacency row resident in a private row cache. Every later row is broadcast to all units at once, one word per cycle. For each broadcast row, every unit ANDs the incoming word with the matching word of its cached row. It counts the set bits in a pipelined adder tree and sums the per-word counts over the whole row.

When the row-end word has passed through the tree, each unit hands its total, tagged with the pair (cached row, streamed row), to a shift chain that runs through all units. The chain then presents one result per cycle on a serial output. A consecutive block of K rows is loaded first. All higher-numbered rows are then streamed past it. Adding units raises the number of pairs counted per streamed row, and the input bandwidth stays the same.

A stall input freezes the broadcast register, the adder trees, the accumulators and the result chain together.

Top module: `cooc_array`

## Requirements
- R1: For a streamed row v and a cached row u, the reported count equals the sum, over all words of the row, of the number of bit positions where both rows hold a 1. The result carries u in out_u and v in out_v.
- R2: A beat with in_load=1 writes in_data into the cache of the unit selected by in_unit. The word position is counted from 0 at the beat with in_sof=1. The in_row value on that in_sof beat becomes the unit's row index. Load beats never produce a result.
- R3: A beat with in_load=0 is broadcast to all units. At the end of the row, each unit whose cached row index is strictly less than the streamed row index emits exactly one result. Units with an equal or larger index emit nothing.
- R4: Results of one row leave on the output one per cycle, lowest unit index first. Units that emit nothing leave no entry. No result is lost or repeated.
- R5: The first result of a row is visible on the output log2(W)+1 clock edges after the edge that accepts the row-end word.
- R6: While stall is high, no input beat is accepted, the outputs hold their values, and counts are unaffected.
- R7: Each unit's running sum restarts from zero after a row-end, so every row's count is independent of earlier rows.
- R8: After reset, out_valid is low and every unit is unloaded. An unloaded unit emits no result for any streamed row.
- R9: Input rules: a row is at most MAX_WORDS words long, and successive row-end words are at least K accepted cycles apart.
- R10: A row of MAX_WORDS words, all ones, matched against an identical all-ones cached row reports W*MAX_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Freezes the whole block for the cycle |
| in_valid | input | 1 | Input word present |
| in_load | input | 1 | 1: cache load beat, 0: streamed beat |
| in_unit | input | UNIT_W | Target unit of a load beat |
| in_sof | input | 1 | First word of a row |
| in_eof | input | 1 | Last word of a row |
| in_row | input | ROW_W | Row index of the current row |
| in_data | input | W | Adjacency word |
| out_valid | output | 1 | A result is presented |
| out_u | output | ROW_W | Cached row index of the result |
| out_v | output | ROW_W | Streamed row index of the result |
| out_count | output | CNT_W | Co-occurrence count |

## Verification
The assertions assume that rows never exceed MAX_WORDS words. They also assume that row-end words are at least K accepted cycles apart, so the shift chain has emptied before it is reloaded. Caches are not reloaded while a row that uses them is still entering the trees. The stimulus keeps to these rules by ending every streamed row with K idle cycles that are counted only on unstalled edges, and by loading a new block only between rows. Random stall cycles are applied on top of this. Because stall freezes every stage alike, the spacing counted in accepted cycles is preserved.

// File: rtl/cooc_pkg.sv
package cooc_pkg;

    // Classification of a broadcast beat.
    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_LOAD   = 2'd1,
        BK_STREAM = 2'd2
    } beat_kind_e;

    // Width that holds a full-row count of word_w * max_words.
    function automatic int count_width(int word_w, int max_words);
        return $clog2(word_w * max_words + 1);
    endfunction

endpackage

// File: rtl/cooc_popcount_tree.sv
module cooc_popcount_tree #(
    parameter int W     = 256,
    parameter int TAG_W = 34,
    localparam int LEVELS = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [W-1:0]      in_bits,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic [LEVELS:0]   out_sum
);

    // One registered adder level per generate step; level l holds
    // W >> (l+1) partial sums of width l+2.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int N  = W >> (l + 1);
        localparam int SW = l + 2;
        localparam int PW = l + 1;

        logic [2*N*PW-1:0] src;
        logic              src_v;
        logic [TAG_W-1:0]  src_tag;

        logic [N*SW-1:0]   s_d, s_q;
        logic              v_d, v_q;
        logic [TAG_W-1:0]  tag_d, tag_q;

        if (l == 0) begin : g_in
            assign src     = in_bits;
            assign src_v   = in_valid;
            assign src_tag = in_tag;
        end else begin : g_chain
            assign src     = g_lvl[l-1].s_q;
            assign src_v   = g_lvl[l-1].v_q;
            assign src_tag = g_lvl[l-1].tag_q;
        end

        always_comb begin
            s_d   = s_q;
            v_d   = v_q;
            tag_d = tag_q;
            if (!stall) begin
                v_d   = src_v;
                tag_d = src_tag;
                for (int i = 0; i < N; i++) begin
                    s_d[i*SW +: SW] = SW'(src[2*i*PW +: PW])
                                    + SW'(src[(2*i+1)*PW +: PW]);
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_q   <= '0;
                v_q   <= 1'b0;
                tag_q <= '0;
            end else begin
                s_q   <= s_d;
                v_q   <= v_d;
                tag_q <= tag_d;
            end
        end
    end

    assign out_valid = g_lvl[LEVELS-1].v_q;
    assign out_tag   = g_lvl[LEVELS-1].tag_q;
    assign out_sum   = g_lvl[LEVELS-1].s_q;

    // R6: a stalled cycle leaves the tree output untouched.
    a_r6_tree_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(out_valid) && $stable(out_sum) && $stable(out_tag)));

    // R1: one word never counts more bits than it has.
    a_r1_word_bound: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum <= (LEVELS+1)'(W)));

endmodule

// File: rtl/cooc_unit.sv
module cooc_unit
    import cooc_pkg::*;
#(
    parameter int W         = 256,
    parameter int MAX_WORDS = 16,
    parameter int ROW_W     = 16,
    parameter int UNIT_W    = 2,
    parameter int UNIT_ID   = 0,
    localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int CNT_W  = count_width(W, MAX_WORDS),
    localparam int LEVELS = $clog2(W),
    localparam int TAG_W  = 2 + 2*ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              b_valid,
    input  logic              b_load,
    input  logic [UNIT_W-1:0] b_unit,
    input  logic              b_sof,
    input  logic              b_eof,
    input  logic [ROW_W-1:0]  b_row,
    input  logic [IDX_W-1:0]  b_widx,
    input  logic [W-1:0]      b_data,
    output logic              cap,
    output logic              res_ok,
    output logic [ROW_W-1:0]  res_u,
    output logic [ROW_W-1:0]  res_v,
    output logic [CNT_W-1:0]  res_count
);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] acc;
    } ustate_t;

    ustate_t s_d, s_q;

    logic [W-1:0] cache_q [MAX_WORDS];
    logic         mine;
    logic [W-1:0] anded;
    logic [TAG_W-1:0] tag_in, t_tag;
    logic         t_valid;
    logic [LEVELS:0] t_sum;
    logic         t_eof;
    logic [CNT_W-1:0] sum;

    assign mine = b_valid && b_load && (b_unit == UNIT_W'(UNIT_ID));

    // Row cache: a plain memory, written only by this unit's load beats.
    always_ff @(posedge clk) begin
        if (!stall && mine) begin
            cache_q[b_widx] <= b_data;
        end
    end

    assign anded  = b_data & cache_q[b_widx];
    // Tag travels with the data: end marker, pair-order flag, u, v.
    assign tag_in = {b_eof, (s_q.row < b_row), s_q.row, b_row};

    cooc_popcount_tree #(
        .W     (W),
        .TAG_W (TAG_W)
    ) u_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .in_valid  (b_valid && !b_load),
        .in_tag    (tag_in),
        .in_bits   (anded),
        .out_valid (t_valid),
        .out_tag   (t_tag),
        .out_sum   (t_sum)
    );

    assign t_eof = t_tag[TAG_W-1];
    assign sum   = s_q.acc + CNT_W'(t_sum);

    always_comb begin
        s_d = s_q;
        cap = 1'b0;
        if (!stall) begin
            if (mine && b_sof) begin
                s_d.row = b_row;
            end
            if (t_valid) begin
                if (t_eof) begin
                    cap       = 1'b1;
                    s_d.acc   = '0;
                end else begin
                    s_d.acc   = sum;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.row <= '1;
            s_q.acc <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign res_ok    = t_tag[TAG_W-2];
    assign res_u     = t_tag[2*ROW_W-1:ROW_W];
    assign res_v     = t_tag[ROW_W-1:0];
    assign res_count = sum;

    // R10: a row total never exceeds the full-row bit count.
    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> (res_count <= CNT_W'(W * MAX_WORDS)));

    // R7: the running sum restarts after each captured row.
    a_r7_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (s_q.acc == '0));

    // R3: a flagged result always has its cached row below the streamed row.
    a_r3_order_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && res_ok) |-> (res_u < res_v));

endmodule

// File: rtl/cooc_result_chain.sv
module cooc_result_chain #(
    parameter int K     = 4,
    parameter int ROW_W = 16,
    parameter int CNT_W = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               cap,
    input  logic [K-1:0]       ld_ok,
    input  logic [K*ROW_W-1:0] ld_u,
    input  logic [K*ROW_W-1:0] ld_v,
    input  logic [K*CNT_W-1:0] ld_cnt,
    output logic               out_valid,
    output logic [ROW_W-1:0]   out_u,
    output logic [ROW_W-1:0]   out_v,
    output logic [CNT_W-1:0]   out_count
);

    typedef struct packed {
        logic             ok;
        logic [ROW_W-1:0] u;
        logic [ROW_W-1:0] v;
        logic [CNT_W-1:0] cnt;
    } slot_t;

    slot_t [K-1:0] sl_d, sl_q;
    logic  [K-1:0] busy;

    always_comb begin
        sl_d = sl_q;
        if (!stall) begin
            if (cap) begin
                for (int k = 0; k < K; k++) begin
                    sl_d[k].ok  = ld_ok[k];
                    sl_d[k].u   = ld_u[k*ROW_W +: ROW_W];
                    sl_d[k].v   = ld_v[k*ROW_W +: ROW_W];
                    sl_d[k].cnt = ld_cnt[k*CNT_W +: CNT_W];
                end
            end else begin
                for (int k = 0; k < K-1; k++) begin
                    sl_d[k] = sl_q[k+1];
                end
                sl_d[K-1] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_q <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    always_comb begin
        for (int k = 0; k < K; k++) begin
            busy[k] = sl_q[k].ok;
        end
    end

    assign out_valid = sl_q[0].ok;
    assign out_u     = sl_q[0].u;
    assign out_v     = sl_q[0].v;
    assign out_count = sl_q[0].cnt;

    // R9: the chain must have emptied behind the head before a reload.
    a_r9_chain_drained: assert property (@(posedge clk) disable iff (!rst_n)
        cap |-> ($countones(busy) <= 1 && !(|(busy >> 1))));

    // R6: the presented result holds through a stall.
    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(sl_q[0]));

    // R4: without a reload the head takes the next slot's content.
    a_r4_shift_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !cap) |=> (sl_q[0] == $past(sl_q[1])));

endmodule

// File: rtl/cooc_array.sv
module cooc_array
    import cooc_pkg::*;
#(
    parameter int K         = 4,
    parameter int W         = 256,
    parameter int MAX_WORDS = 16,
    parameter int ROW_W     = 16,
    localparam int UNIT_W = (K > 1) ? $clog2(K) : 1,
    localparam int CNT_W  = count_width(W, MAX_WORDS),
    localparam int IDX_W  = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1,
    localparam int PTR_W  = $clog2(MAX_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall,
    input  logic              in_valid,
    input  logic              in_load,
    input  logic [UNIT_W-1:0] in_unit,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [W-1:0]      in_data,
    output logic              out_valid,
    output logic [ROW_W-1:0]  out_u,
    output logic [ROW_W-1:0]  out_v,
    output logic [CNT_W-1:0]  out_count
);

    // Broadcast register: the root of the replication network.
    typedef struct packed {
        beat_kind_e        kind;
        logic [UNIT_W-1:0] unit;
        logic              sof;
        logic              eof;
        logic [ROW_W-1:0]  row;
        logic [IDX_W-1:0]  widx;
        logic [W-1:0]      data;
        logic [PTR_W-1:0]  ptr;
    } top_t;

    top_t t_d, t_q;
    logic [PTR_W-1:0] idx;

    always_comb begin
        t_d = t_q;
        idx = in_sof ? '0 : t_q.ptr;
        if (!stall) begin
            if (!in_valid)    t_d.kind = BK_IDLE;
            else if (in_load) t_d.kind = BK_LOAD;
            else              t_d.kind = BK_STREAM;
            t_d.unit = in_unit;
            t_d.sof  = in_sof;
            t_d.eof  = in_eof;
            t_d.row  = in_row;
            t_d.widx = IDX_W'(idx);
            t_d.data = in_data;
            if (in_valid) begin
                t_d.ptr = in_eof ? '0 : idx + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q      <= '0;
            t_q.kind <= BK_IDLE;
        end else begin
            t_q <= t_d;
        end
    end

    logic [K-1:0]       cap_vec;
    logic [K-1:0]       ok_vec;
    logic [K*ROW_W-1:0] u_bus;
    logic [K*ROW_W-1:0] v_bus;
    logic [K*CNT_W-1:0] cnt_bus;

    for (genvar k = 0; k < K; k++) begin : g_unit
        cooc_unit #(
            .W         (W),
            .MAX_WORDS (MAX_WORDS),
            .ROW_W     (ROW_W),
            .UNIT_W    (UNIT_W),
            .UNIT_ID   (k)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .stall     (stall),
            .b_valid   (t_q.kind != BK_IDLE),
            .b_load    (t_q.kind == BK_LOAD),
            .b_unit    (t_q.unit),
            .b_sof     (t_q.sof),
            .b_eof     (t_q.eof),
            .b_row     (t_q.row),
            .b_widx    (t_q.widx),
            .b_data    (t_q.data),
            .cap       (cap_vec[k]),
            .res_ok    (ok_vec[k]),
            .res_u     (u_bus[k*ROW_W +: ROW_W]),
            .res_v     (v_bus[k*ROW_W +: ROW_W]),
            .res_count (cnt_bus[k*CNT_W +: CNT_W])
        );
    end

    cooc_result_chain #(
        .K     (K),
        .ROW_W (ROW_W),
        .CNT_W (CNT_W)
    ) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .stall     (stall),
        .cap       (cap_vec[0]),
        .ld_ok     (ok_vec),
        .ld_u      (u_bus),
        .ld_v      (v_bus),
        .ld_cnt    (cnt_bus),
        .out_valid (out_valid),
        .out_u     (out_u),
        .out_v     (out_v),
        .out_count (out_count)
    );

    // R3: every unit sees the same broadcast, so all capture together.
    a_r3_caps_agree: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_vec == '0) || (&cap_vec));

    // R3: only pairs with the cached row below the streamed row leave.
    a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_u < out_v));

    // R9: a row never runs past the cache depth.
    a_r9_row_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && in_valid && !in_sof) |-> (t_q.ptr < PTR_W'(MAX_WORDS)));

endmodule

// File: tb/sim_cooc_array.sv
module sim_cooc_array;

    localparam int CLK_PERIOD = 10;
    localparam int K       = 4;
    localparam int W       = 256;
    localparam int MW      = 16;
    localparam int ROW_W   = 16;
    localparam int UNIT_W  = 2;
    localparam int CNT_W   = $clog2(W*MW+1);
    // Output visible log2(W)+1 edges after acceptance; the bench counts
    // negedges, which adds one.
    localparam int EXP_GAP = $clog2(W) + 2;

    // Scenario table: block base row, row length, data pattern, stall on.
    // Patterns: 0 hashed, 1 all ones, 2 all zeros, 3 sparse.
    typedef struct packed {
        int base;
        int nwords;
        int pat;
        int stl;
    } scen_t;

    localparam int NSCEN = 5;
    localparam scen_t SCEN [NSCEN] = '{
        '{0,  3,  0, 0},
        '{10, 16, 1, 0},
        '{20, 1,  0, 1},
        '{33, 5,  3, 1},
        '{40, 4,  2, 0}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic stall = 1'b0;
    logic in_valid, in_load, in_sof, in_eof;
    logic [UNIT_W-1:0] in_unit;
    logic [ROW_W-1:0]  in_row;
    logic [W-1:0]      in_data;
    logic              out_valid;
    logic [ROW_W-1:0]  out_u, out_v;
    logic [CNT_W-1:0]  out_count;

    cooc_array #(
        .K (K), .W (W), .MAX_WORDS (MW), .ROW_W (ROW_W)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .stall (stall),
        .in_valid (in_valid), .in_load (in_load), .in_unit (in_unit),
        .in_sof (in_sof), .in_eof (in_eof), .in_row (in_row),
        .in_data (in_data), .out_valid (out_valid), .out_u (out_u),
        .out_v (out_v), .out_count (out_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit stall_en = 1'b0;
    int cyc = 0;
    int acc_cyc = 0;
    bit lat_armed = 1'b0;

    typedef struct { int u; int v; int cnt; } exp_t;
    exp_t expq [$];

    function automatic logic [W-1:0] row_word(int row, int word, int pat);
        logic [W-1:0] r;
        logic [31:0] x, y;
        for (int i = 0; i < W/32; i++) begin
            x = 32'(row) * 32'h9E3779B1 ^ 32'(word + 1) * 32'h85EBCA6B
              ^ 32'(i + 7) * 32'hC2B2AE35;
            x = x ^ (x >> 15);
            x = x * 32'h2C1B3C6D;
            x = x ^ (x >> 12);
            y = x * 32'h27D4EB2F;
            y = y ^ (y >> 13);
            case (pat)
                1:       r[i*32 +: 32] = '1;
                2:       r[i*32 +: 32] = '0;
                3:       r[i*32 +: 32] = x & y;
                default: r[i*32 +: 32] = x;
            endcase
        end
        return r;
    endfunction

    function automatic int pair_count(int u, int v, int n, int pat);
        int c = 0;
        for (int w = 0; w < n; w++) begin
            c += $countones(row_word(u, w, pat) & row_word(v, w, pat));
        end
        return c;
    endfunction

    // Random stall, changed just after each edge.
    always @(posedge clk) begin
        #1;
        stall = stall_en && ($urandom_range(0, 3) == 0);
    end

    task automatic beat(bit ld, int unit, bit sof, bit eof, int row,
                        logic [W-1:0] d);
        in_valid = 1'b1;
        in_load  = ld;
        in_unit  = UNIT_W'(unit);
        in_sof   = sof;
        in_eof   = eof;
        in_row   = ROW_W'(row);
        in_data  = d;
        do @(posedge clk); while (stall);
        if (eof && !ld) acc_cyc = cyc;
        #1;
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (stall);
        end
        #1;
    endtask

    task automatic send_row(bit ld, int unit, int row, int n, int pat);
        for (int w = 0; w < n; w++) begin
            beat(ld, unit, w == 0, w == n-1, row, row_word(row, w, pat));
        end
    endtask

    // R3: expected results for every unit whose block row lies below v.
    task automatic stream_row(int v, int base, int n, int pat);
        for (int k = 0; k < K; k++) begin
            if (base + k < v) begin
                expq.push_back('{base + k, v, pair_count(base + k, v, n, pat)});
            end
        end
        send_row(1'b0, 0, v, n, pat);
        idle(K);
    endtask

    // Output monitor, sampling between edges.
    bit prev_hold = 1'b0;
    logic [ROW_W-1:0] pu, pv;
    logic [CNT_W-1:0] pc;

    always @(negedge clk) begin
        exp_t e;
        cyc++;
        if (rst_n === 1'b1) begin
            if (prev_hold) begin
                checks++;
                if (!out_valid || out_u !== pu || out_v !== pv || out_count !== pc) begin
                    failures++;
                    $display("FAIL R6 held output: got v=%0d u=%0d n=%0d cnt=%0d exp u=%0d n=%0d cnt=%0d",
                             out_valid, out_u, out_v, out_count, pu, pv, pc);
                end
            end
            if (out_valid && !stall) begin
                if (lat_armed) begin
                    lat_armed = 1'b0;
                    checks++;
                    if (cyc - acc_cyc != EXP_GAP) begin
                        failures++;
                        $display("FAIL R5 latency: got %0d expected %0d",
                                 cyc - acc_cyc, EXP_GAP);
                    end
                end
                checks++;
                if (expq.size() == 0) begin
                    failures++;
                    $display("FAIL R4 unexpected result: got u=%0d v=%0d cnt=%0d expected none",
                             out_u, out_v, out_count);
                end else begin
                    e = expq.pop_front();
                    if (int'(out_u) != e.u || int'(out_v) != e.v || int'(out_count) != e.cnt) begin
                        failures++;
                        $display("FAIL R1/R3 result: got u=%0d v=%0d cnt=%0d expected u=%0d v=%0d cnt=%0d",
                                 out_u, out_v, out_count, e.u, e.v, e.cnt);
                    end
                end
            end
            prev_hold = stall && out_valid;
            pu = out_u;
            pv = out_v;
            pc = out_count;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_load  = 1'b0;
        in_unit  = '0;
        in_sof   = 1'b0;
        in_eof   = 1'b0;
        in_row   = '0;
        in_data  = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8: reset state.
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R8 reset: got out_valid=%0d expected 0", out_valid);
        end

        // R8 / R3 / R5: only unit 0 loaded (row 5); stream row 9.
        // Units 1..3 are unloaded and must stay silent.
        // R2: the load beats themselves produce nothing.
        #1;
        send_row(1'b1, 0, 5, 2, 0);
        idle(2);
        lat_armed = 1'b1;
        expq.push_back('{5, 9, pair_count(5, 9, 2, 0)});
        send_row(1'b0, 0, 9, 2, 0);
        idle(20);

        // Table walk: each scenario loads a block of K rows, then streams
        // a row below the block (R3), a row equal to unit 1 (R3), the row
        // just above the block and one further row (R1, R7). Scenario 1 is
        // the full-length all-ones case (R10); scenarios 2 and 3 stall (R6).
        for (int s = 0; s < NSCEN; s++) begin
            stall_en = SCEN[s].stl != 0;
            for (int k = 0; k < K; k++) begin
                send_row(1'b1, k, SCEN[s].base + k, SCEN[s].nwords, SCEN[s].pat);
            end
            if (SCEN[s].base > 0) begin
                stream_row(SCEN[s].base - 1, SCEN[s].base, SCEN[s].nwords, SCEN[s].pat);
            end
            stream_row(SCEN[s].base + 1, SCEN[s].base, SCEN[s].nwords, SCEN[s].pat);
            stream_row(SCEN[s].base + K, SCEN[s].base, SCEN[s].nwords, SCEN[s].pat);
            stream_row(SCEN[s].base + K + 3, SCEN[s].base, SCEN[s].nwords, SCEN[s].pat);
            idle(4);
        end
        stall_en = 1'b0;
        idle(40);

        // R4: every expected result arrived.
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL R4 missing results: got %0d left expected 0", expq.size());
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule